// File: doc/BRIEF.md
# Framed Serial Word Transmitter

This block takes parallel words from an external first-word-fall-through FIFO and sends them on one serial line as self-clocking Manchester code. A frame is everything the FIFO holds once a send is requested. Each word carries a start marker and a parity bit and ends in a stop bit. The next word's start bit comes right after that stop bit. Words that the FIFO gains while a frame is still going out are added to that frame. The transmitter halts when the FIFO has no more words.

All timing comes from one clock running at twice the bit rate. Each bit fills two clock cycles. A free-running half-bit phase makes the line carry an encoded zero when no frame is being sent, so a far-end decoder keeps its lock. The line output comes straight from a flop, so it can only change on a clock edge and cannot glitch. The cost is one clock cycle, which is half a bit.

Top module: `framed_word_tx`

## Requirements
- R1: Each word goes out as a start bit of value 1, then the 16 data bits starting with bit 15, then a parity bit, then a stop bit of value 0.
- R2: The parity bit is the XOR of the 16 data bits, which makes the count of ones across data and parity even.
- R3: Driving req_n low while fifo_empty is low starts a frame at the next bit boundary. A single-cycle pulse is enough because the request is remembered. busy_n goes low in the cycle after the first word is taken and stays low until the frame ends.
- R4: tx_strobe is high for one cycle for each word sent, and only while fifo_empty is low. The word on tx_data is captured at the clock edge that ends that cycle.
- R5: If fifo_empty is low when a stop bit ends, the next word's start bit follows at once, in the same frame. This also applies to words pushed during the frame.
- R6: If the FIFO is empty when a stop bit ends, the frame ends: busy_n returns high and the line carries idle bits of value 0.
- R7: Each bit takes two clock cycles on line_out: first the inverse of the bit, then the bit itself. The line is registered, one clock cycle behind the bit timing. Line cycles 2b+1 and 2b+2 after reset carry bit b, and idle bits count as value 0.
- R8: A request made while fifo_empty is high is ignored. busy_n stays high, and no start happens later when data arrives without a new request.
- R9: While rst_n is low, busy_n is high, tx_strobe is low and line_out is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock at twice the bit rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_n | input | 1 | Active-low request to send the FIFO contents |
| fifo_empty | input | 1 | High when the source FIFO holds no word |
| tx_data | input | 16 | Head word of the source FIFO |
| tx_strobe | output | 1 | Pop pulse: the head word is taken at the next edge |
| busy_n | output | 1 | Low while a frame is being sent |
| line_out | output | 1 | Manchester-coded serial line |

## Verification
The assertions assume that this block is the only consumer of the FIFO. Under that assumption, fifo_empty can rise only after a tx_strobe, and a non-empty FIFO cannot drain on its own between a request and the bit boundary that acts on it. The bench models the FIFO as a queue that removes its head only in the cycle after a strobe. The bench drives all inputs half a cycle away from the sampling edge. It decodes the line by pairing half-bit samples counted from reset release. Each decoded word is compared against a queue of expected words, and each entry also records whether that word should follow the previous one inside the same frame.

// File: rtl/txw_pkg.sv
package txw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_START  = 3'd1,
        ST_DATA   = 3'd2,
        ST_PARITY = 3'd3,
        ST_STOP   = 3'd4
    } txw_state_e;

    localparam logic START_LVL = 1'b1;
    localparam logic STOP_LVL  = 1'b0;
    localparam logic IDLE_LVL  = STOP_LVL;

endpackage

// File: rtl/txw_parity.sv
module txw_parity #(
    parameter int WORD_W = 16
) (
    input  logic [WORD_W-1:0] word_i,
    output logic              par_o
);

    logic [WORD_W-1:0] chain;

    generate
        for (genvar i = 0; i < WORD_W; i++) begin : g_xor
            if (i == 0) begin : g_first
                assign chain[i] = word_i[i];
            end else begin : g_next
                assign chain[i] = chain[i-1] ^ word_i[i];
            end
        end
    endgenerate

    assign par_o = chain[WORD_W-1];

endmodule

// File: rtl/txw_manchester.sv
module txw_manchester (
    input  logic clk,
    input  logic rst_n,
    input  logic nrz_i,
    output logic tick_o,
    output logic line_o
);

    typedef struct packed {
        logic phase;
        logic line;
    } enc_t;

    enc_t enc_d, enc_q;

    always_comb begin
        enc_d       = enc_q;
        enc_d.phase = ~enc_q.phase;
        enc_d.line  = enc_q.phase ? nrz_i : ~nrz_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            enc_q <= '0;
        end else begin
            enc_q <= enc_d;
        end
    end

    assign tick_o = enc_q.phase;
    assign line_o = enc_q.line;

endmodule

// File: rtl/txw_framer.sv
module txw_framer
    import txw_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              req_n,
    input  logic              fifo_empty,
    input  logic [WORD_W-1:0] word_i,
    input  logic              par_i,
    output logic              strobe_o,
    output logic              busy_n_o,
    output logic              nrz_o
);

    localparam int CNT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(WORD_W - 1);

    typedef struct packed {
        txw_state_e        state;
        logic [WORD_W-1:0] shift;
        logic [CNT_W-1:0]  cnt;
        logic              par;
        logic              pend;
    } fr_t;

    fr_t  fr_d, fr_q;
    logic load;

    always_comb begin
        fr_d = fr_q;
        load = 1'b0;
        unique case (fr_q.state)
            ST_IDLE: begin
                if (!req_n && !fifo_empty) fr_d.pend = 1'b1;
                if (tick_i && !fifo_empty && (fr_q.pend || !req_n)) load = 1'b1;
            end
            ST_START: begin
                if (tick_i) begin
                    fr_d.state = ST_DATA;
                    fr_d.cnt   = LAST_IDX;
                end
            end
            ST_DATA: begin
                if (tick_i) begin
                    fr_d.shift = fr_q.shift << 1;
                    if (fr_q.cnt == '0) fr_d.state = ST_PARITY;
                    else                fr_d.cnt   = fr_q.cnt - 1'b1;
                end
            end
            ST_PARITY: begin
                if (tick_i) fr_d.state = ST_STOP;
            end
            ST_STOP: begin
                if (tick_i) begin
                    if (!fifo_empty) load = 1'b1;
                    else             fr_d.state = ST_IDLE;
                end
            end
            default: fr_d.state = ST_IDLE;
        endcase
        if (load) begin
            fr_d.state = ST_START;
            fr_d.shift = word_i;
            fr_d.par   = par_i;
            fr_d.pend  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fr_q <= '{state: ST_IDLE, shift: '0, cnt: '0, par: 1'b0, pend: 1'b0};
        end else begin
            fr_q <= fr_d;
        end
    end

    always_comb begin
        unique case (fr_q.state)
            ST_START:  nrz_o = START_LVL;
            ST_DATA:   nrz_o = fr_q.shift[WORD_W-1];
            ST_PARITY: nrz_o = fr_q.par;
            ST_STOP:   nrz_o = STOP_LVL;
            default:   nrz_o = IDLE_LVL;
        endcase
    end

    assign strobe_o = load;
    assign busy_n_o = (fr_q.state == ST_IDLE);

endmodule

// File: rtl/framed_word_tx.sv
module framed_word_tx #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_n,
    input  logic              fifo_empty,
    input  logic [WORD_W-1:0] tx_data,
    output logic              tx_strobe,
    output logic              busy_n,
    output logic              line_out
);

    logic par;
    logic tick;
    logic nrz;

    txw_parity #(.WORD_W(WORD_W)) parity_i (
        .word_i (tx_data),
        .par_o  (par)
    );

    txw_framer #(.WORD_W(WORD_W)) framer_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick),
        .req_n      (req_n),
        .fifo_empty (fifo_empty),
        .word_i     (tx_data),
        .par_i      (par),
        .strobe_o   (tx_strobe),
        .busy_n_o   (busy_n),
        .nrz_o      (nrz)
    );

    txw_manchester enc_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .nrz_i  (nrz),
        .tick_o (tick),
        .line_o (line_out)
    );

endmodule

// File: rtl/framed_word_tx_sva.sv
module framed_word_tx_sva (
    input logic clk,
    input logic rst_n,
    input logic fifo_empty,
    input logic tx_strobe,
    input logic busy_n,
    input logic line_out
);

    assert_pop_nonempty_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_strobe |-> !fifo_empty);

    assert_pop_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_strobe |=> !tx_strobe);

    assert_busy_after_pop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_n) |-> $past(tx_strobe));

    assert_empty_no_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_n && fifo_empty) |=> busy_n);

    assert_chain_stays_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_strobe && !busy_n) |=> !busy_n);

    assert_mid_bit_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (line_out == $past(line_out)) |=> (line_out != $past(line_out)));

endmodule

bind framed_word_tx framed_word_tx_sva sva_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .fifo_empty (fifo_empty),
    .tx_strobe  (tx_strobe),
    .busy_n     (busy_n),
    .line_out   (line_out)
);

// File: tb/framed_word_tx_tb_top.sv
`timescale 1ns/100ps
module framed_word_tx_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_n = 1'b1;
    logic        fifo_empty = 1'b1;
    logic [15:0] tx_data = '0;
    logic        tx_strobe;
    logic        busy_n;
    logic        line_out;

    int n_cmp = 0;
    int n_bad = 0;
    int n_pushed = 0;
    int n_popped = 0;
    logic strobe_l = 1'b0;

    logic [15:0] fifo_m[$];
    logic [15:0] exp_word[$];
    bit          exp_cont[$];

    always #2 clk = ~clk;

    framed_word_tx #(.WORD_W(16)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_n      (req_n),
        .fifo_empty (fifo_empty),
        .tx_data    (tx_data),
        .tx_strobe  (tx_strobe),
        .busy_n     (busy_n),
        .line_out   (line_out)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    // FIFO model: head leaves only in the cycle after a strobe
    initial begin
        forever begin
            @(negedge clk);
            #0.2;
            if (strobe_l) begin
                void'(fifo_m.pop_front());
                n_popped++;
            end
            fifo_empty = (fifo_m.size() == 0);
            tx_data    = (fifo_m.size() == 0) ? 16'h0 : fifo_m[0];
            #0.4;
            strobe_l = tx_strobe;
        end
    end

    // driver: pushes one word into the FIFO model and the scoreboard
    task automatic push_word(input logic [15:0] w, input bit cont);
        @(negedge clk);
        fifo_m.push_back(w);
        exp_word.push_back(w);
        exp_cont.push_back(cont);
        n_pushed++;
    endtask

    task automatic pulse_req(input int cycles);
        @(negedge clk);
        req_n = 1'b0;
        repeat (cycles) @(negedge clk);
        req_n = 1'b1;
    endtask

    task automatic wait_idle();
        int n = 0;
        while ((exp_word.size() != 0 || !busy_n) && n < 4000) begin
            @(negedge clk);
            n++;
        end
        repeat (6) @(negedge clk);
    endtask

    // monitor: decode half-bit pairs counted from reset release
    task automatic get_bit(output logic b);
        logic a;
        @(posedge clk); @(negedge clk); a = line_out;
        @(posedge clk); @(negedge clk); b = line_out;
        check(a === ~b, "R7 half-bit complement", {31'd0, a}, {31'd0, ~b});
    endtask

    task automatic monitor();
        bit prev_stop = 1'b0;
        forever begin
            logic b, p, s;
            logic [15:0] w;
            get_bit(b);
            if (b === 1'b1) begin
                for (int i = 15; i >= 0; i--) begin
                    logic db;
                    get_bit(db);
                    w[i] = db;
                end
                get_bit(p);
                get_bit(s);
                if (exp_word.size() == 0) begin
                    check(1'b0, "R8 unexpected start bit", {16'd0, w}, 32'd0);
                end else begin
                    logic [15:0] ew;
                    bit ec;
                    ew = exp_word.pop_front();
                    ec = exp_cont.pop_front();
                    check(w === ew, "R1 data word", {16'd0, w}, {16'd0, ew});
                    check(p === ^ew, "R2 even parity", {31'd0, p}, {31'd0, ^ew});
                    check(prev_stop == ec, "R5 frame continuation", {31'd0, prev_stop}, {31'd0, ec});
                end
                check(s === 1'b0, "R1 stop bit", {31'd0, s}, 32'd0);
                prev_stop = 1'b1;
            end else begin
                prev_stop = 1'b0;
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not complete actual=hung expected=done");
        summary();
        $finish;
    end

    initial begin
        // R9 reset state
        repeat (5) @(negedge clk);
        check(busy_n === 1'b1, "R9 busy_n in reset", {31'd0, busy_n}, 32'd1);
        check(tx_strobe === 1'b0, "R9 strobe in reset", {31'd0, tx_strobe}, 32'd0);
        check(line_out === 1'b0, "R9 line in reset", {31'd0, line_out}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        fork
            monitor();
        join_none

        // R8: request with empty FIFO is ignored and not remembered
        pulse_req(10);
        check(busy_n === 1'b1, "R8 busy_n after empty request", {31'd0, busy_n}, 32'd1);
        push_word(16'hC3A5, 1'b0);
        repeat (12) @(negedge clk);
        check(busy_n === 1'b1, "R8 no late start", {31'd0, busy_n}, 32'd1);
        check(n_popped == 0, "R8 no strobe", n_popped, 0);

        // R3: single-cycle request starts the frame
        pulse_req(1);
        repeat (3) @(negedge clk);
        check(busy_n === 1'b0, "R3 busy_n low in frame", {31'd0, busy_n}, 32'd0);
        wait_idle();
        check(busy_n === 1'b1, "R6 busy_n high after frame", {31'd0, busy_n}, 32'd1);
        check(n_popped == n_pushed, "R4 one strobe per word", n_popped, n_pushed);

        // R1 R2 R5: three-word frame with varied parity
        push_word(16'h0001, 1'b0);
        push_word(16'hFFFE, 1'b1);
        push_word(16'h0000, 1'b1);
        pulse_req(1);
        wait_idle();
        check(n_popped == n_pushed, "R4 strobes for three-word frame", n_popped, n_pushed);

        // R5: words pushed during a frame join it
        push_word(16'h1234, 1'b0);
        pulse_req(1);
        repeat (20) @(negedge clk);
        check(busy_n === 1'b0, "R3 busy_n held during frame", {31'd0, busy_n}, 32'd0);
        push_word(16'hBEEF, 1'b1);
        push_word(16'h7F80, 1'b1);
        wait_idle();
        check(busy_n === 1'b1, "R6 halt after appended words", {31'd0, busy_n}, 32'd1);

        // R3: request on each clock phase
        for (int k = 0; k < 2; k++) begin
            push_word(16'h8000 >> (k * 5), 1'b0);
            repeat (k) @(negedge clk);
            pulse_req(1);
            wait_idle();
        end

        // mixed frames of growing length
        for (int f = 1; f <= 4; f++) begin
            for (int i = 0; i < f; i++) begin
                logic [15:0] w;
                w = 16'(((f * 7 + i) * 16'h03B5) ^ 16'h0A0F);
                push_word(w, i != 0);
            end
            pulse_req(2);
            wait_idle();
        end
        check(n_popped == n_pushed, "R4 total strobe count", n_popped, n_pushed);
        check(exp_word.size() == 0, "R1 all words seen", exp_word.size(), 0);

        summary();
        $finish;
    end

endmodule